// File: doc/BRIEF.md
# Cache-Allocate Store Backup Queue

This block keeps an ordered record of stores made by a line-allocating store, so that a later line invalidate can push the saved data back to memory. Each capture request carries a full address, a 32-bit value and a cacheable qualifier. Only cacheable captures are kept, and each one is appended at the tail.

An invalidate request presents an address. The queue compares it, at 32-byte line granularity, against every live entry. The oldest entry that matches is taken out of the queue and sent on a memory write port that has a valid/ready handshake. While that write waits for ready, the block reports busy and ignores new captures and invalidates. A discard command empties the queue without writing anything.

Top module: `store_backup_queue`

## Requirements
- R1: After reset, count is 0, empty is 1, and mem_wr_valid, busy and overflow are all 0.
- R2: A capture with cap_cacheable = 0 has no effect. The count does not change and no entry is added.
- R3: A cacheable capture accepted at a clock edge raises count by one at that edge. The entry joins the tail, so entries keep arrival order.
- R4: An invalidate matches an entry when the two addresses are equal in bits [31:5]. Bits [4:0] are not compared.
- R5: Per invalidate, only the oldest matching entry is replayed. On the edge after the request, mem_wr_valid rises with that entry's full address and data, and count falls by one.
- R6: Removing an entry closes the gap and keeps the order of the entries that remain. This holds for the head, a middle entry and the tail entry.
- R7: An invalidate with no match completes in its own cycle. It causes no write, and count and busy do not change.
- R8: While mem_wr_valid is high and mem_wr_ready is low, busy is 1 and the write address and data stay stable. Captures and invalidates presented in that window are ignored.
- R9: Discard empties the queue at the next edge and writes nothing. A capture or invalidate presented in the same cycle is ignored.
- R10: A cacheable capture presented while count equals DEPTH is dropped. overflow is high for exactly the one cycle after it. An uncached capture when full does not raise overflow.
- R11: A capture and an invalidate in the same cycle are both taken. The matching entry is removed first, and the new entry is then appended behind the remaining ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_valid | input | 1 | Capture request |
| cap_addr | input | 32 | Capture address |
| cap_data | input | 32 | Capture data |
| cap_cacheable | input | 1 | Capture address is cacheable |
| inv_valid | input | 1 | Invalidate request |
| inv_addr | input | 32 | Invalidate address (line compare) |
| discard | input | 1 | Empty the queue without writing |
| mem_wr_valid | output | 1 | Replay write pending |
| mem_wr_addr | output | 32 | Replay write address |
| mem_wr_data | output | 32 | Replay write data |
| mem_wr_ready | input | 1 | Memory accepts the write |
| busy | output | 1 | Replay outstanding; requests are ignored |
| overflow | output | 1 | One-cycle pulse: capture dropped because the queue was full |
| count | output | $clog2(DEPTH+1) | Number of live entries |
| empty | output | 1 | Queue holds no entries |

## Verification
The bench builds the block with DEPTH = 4, which makes a full queue reachable after four captures. With that depth, a single scenario can remove the head, a middle entry and the tail slot, and can also show the overflow pulse and the drop of the extra capture. The line width stays at its default of five offset bits. Addresses are chosen to differ only below bit 5, or only at bit 5 or above, so that both sides of the line compare are exercised.

// File: rtl/sbq_pkg.sv
// Package: shared widths and the entry record for the store backup queue.
// Assumes 32-bit addresses and data, and a 32-byte line.
package sbq_pkg;
    localparam int SBQ_AW        = 32;
    localparam int SBQ_DW        = 32;
    localparam int SBQ_LINE_BITS = 5;

    typedef struct packed {
        logic [SBQ_AW-1:0] addr;
        logic [SBQ_DW-1:0] data;
    } sbq_entry_t;
endpackage

// File: rtl/sbq_store.sv
// Module: entry storage with compaction.
// Holds DEPTH entries with slot 0 as the oldest. In one cycle it can remove
// one slot (later slots shift down) and then append one entry at the new tail.
// Assumes the caller never pushes while full unless a removal happens in the
// same cycle, and that clr takes priority over everything else.
module sbq_store
    import sbq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   rm_en,
    input  logic [IW-1:0]          rm_idx,
    input  logic                   push_en,
    input  sbq_entry_t             push_ent,
    output sbq_entry_t [DEPTH-1:0] ents,
    output logic [CW-1:0]          cnt
);
    sbq_entry_t [DEPTH-1:0] ents_n;
    logic [CW-1:0]          cnt_n;
    logic [CW-1:0]          cnt_rm;

    // Next state: remove and shift first, then append at the tail.
    always_comb begin
        ents_n = ents;
        cnt_rm = cnt;
        if (rm_en) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (IW'(i) >= rm_idx) ents_n[i] = ents[i+1];
            end
            cnt_rm = cnt - 1'b1;
        end
        cnt_n = cnt_rm;
        if (push_en) begin
            ents_n[cnt_rm[IW-1:0]] = push_ent;
            cnt_n = cnt_rm + 1'b1;
        end
    end

    // State registers; clear or reset zeroes the count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt  <= '0;
            ents <= '0;
        end else begin
            cnt  <= cnt_n;
            ents <= ents_n;
        end
    end
endmodule

// File: rtl/sbq_match.sv
// Module: line-match search.
// Compares the address bits above the line offset for every live slot
// (slot index below cnt) and reports the lowest index that hits, which is
// the oldest entry. Purely combinational.
module sbq_match
    import sbq_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int LINE_BITS = SBQ_LINE_BITS,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  sbq_entry_t [DEPTH-1:0] ents,
    input  logic [CW-1:0]          cnt,
    input  logic [SBQ_AW-1:0]      key,
    output logic                   hit,
    output logic [IW-1:0]          hit_idx
);
    logic [DEPTH-1:0] hits;

    // One comparator per slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hits[g] = (CW'(g) < cnt) &&
            (ents[g].addr[SBQ_AW-1:LINE_BITS] == key[SBQ_AW-1:LINE_BITS]);
    end

    // Priority pick: scanning from the top lets the lowest index win.
    always_comb begin
        hit     = |hits;
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hits[i]) hit_idx = IW'(i);
        end
    end
endmodule

// File: rtl/sbq_replay.sv
// Module: replay write register.
// Loads one entry and holds it on the memory write port until ready is seen.
// Assumes load never arrives while a write is pending (the top ignores
// requests when busy).
module sbq_replay
    import sbq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  sbq_entry_t        ent,
    input  logic              ready,
    output logic              valid,
    output logic [SBQ_AW-1:0] addr,
    output logic [SBQ_DW-1:0] data
);
    // Hold the write until it is accepted; load a new one when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            addr  <= '0;
            data  <= '0;
        end else if (valid) begin
            if (ready) valid <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
            addr  <= ent.addr;
            data  <= ent.data;
        end
    end
endmodule

// File: rtl/store_backup_queue.sv
// Module: store backup queue top.
// Captures cacheable stores in arrival order. A line invalidate replays the
// oldest matching entry to memory and removes it; discard empties the queue.
// Requests are ignored while a replay is pending (busy) or when discard is
// asserted. Assumes the requester holds a request until busy is low.
module store_backup_queue
    import sbq_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int LINE_BITS = SBQ_LINE_BITS,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_valid,
    input  logic [SBQ_AW-1:0] cap_addr,
    input  logic [SBQ_DW-1:0] cap_data,
    input  logic              cap_cacheable,
    input  logic              inv_valid,
    input  logic [SBQ_AW-1:0] inv_addr,
    input  logic              discard,
    output logic              mem_wr_valid,
    output logic [SBQ_AW-1:0] mem_wr_addr,
    output logic [SBQ_DW-1:0] mem_wr_data,
    input  logic              mem_wr_ready,
    output logic              busy,
    output logic              overflow,
    output logic [CW-1:0]     count,
    output logic              empty
);
    sbq_entry_t [DEPTH-1:0] ents;
    sbq_entry_t             push_ent;
    logic                   accept, full, cap_req, cap_go, inv_go;
    logic                   hit;
    logic [IW-1:0]          hit_idx;

    // Request gating: no new work while busy or discarding.
    always_comb begin
        accept   = !mem_wr_valid && !discard;
        full     = (count == CW'(DEPTH));
        cap_req  = cap_valid && cap_cacheable && accept;
        cap_go   = cap_req && !full;
        inv_go   = inv_valid && accept && hit;
        push_ent = '{addr: cap_addr, data: cap_data};
    end

    sbq_match #(.DEPTH(DEPTH), .LINE_BITS(LINE_BITS)) u_match (
        .ents    (ents),
        .cnt     (count),
        .key     (inv_addr),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    sbq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (discard),
        .rm_en    (inv_go),
        .rm_idx   (hit_idx),
        .push_en  (cap_go),
        .push_ent (push_ent),
        .ents     (ents),
        .cnt      (count)
    );

    sbq_replay u_replay (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (inv_go),
        .ent   (ents[hit_idx]),
        .ready (mem_wr_ready),
        .valid (mem_wr_valid),
        .addr  (mem_wr_addr),
        .data  (mem_wr_data)
    );

    // Overflow pulse: a cacheable capture was refused because the queue was full.
    always_ff @(posedge clk) begin
        if (!rst_n) overflow <= 1'b0;
        else        overflow <= cap_req && full;
    end

    assign busy  = mem_wr_valid;
    assign empty = (count == '0);
endmodule

// File: rtl/sbq_checker.sv
// Module: property checker for store_backup_queue, attached by bind.
module sbq_checker #(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cap_valid,
    input logic          cap_cacheable,
    input logic          inv_valid,
    input logic          discard,
    input logic          mem_wr_valid,
    input logic [31:0]   mem_wr_addr,
    input logic [31:0]   mem_wr_data,
    input logic          mem_wr_ready,
    input logic          busy,
    input logic          overflow,
    input logic [CW-1:0] count,
    input logic          empty
);
    // R2: an uncached capture alone leaves the count unchanged.
    a_r2_uncached_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid && !cap_cacheable && !inv_valid && !discard |=> count == $past(count));

    // R8: a pending write holds its payload until accepted.
    a_r8_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));

    // R8: the count never grows while busy.
    a_r8_busy_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> count <= $past(count));

    // R9: discard always leaves the queue empty.
    a_r9_discard_empties: assert property (@(posedge clk) disable iff (!rst_n)
        discard |=> empty && count == '0);

    // R10: overflow only follows a full queue.
    a_r10_overflow_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> $past(count) == CW'(DEPTH));

    // R5: a new replay write always follows an invalidate request.
    a_r5_write_from_invalidate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_valid) |-> $past(inv_valid));

    // R3: count stays within depth.
    a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
endmodule

bind store_backup_queue sbq_checker #(.DEPTH(DEPTH)) u_sbq_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cap_valid     (cap_valid),
    .cap_cacheable (cap_cacheable),
    .inv_valid     (inv_valid),
    .discard       (discard),
    .mem_wr_valid  (mem_wr_valid),
    .mem_wr_addr   (mem_wr_addr),
    .mem_wr_data   (mem_wr_data),
    .mem_wr_ready  (mem_wr_ready),
    .busy          (busy),
    .overflow      (overflow),
    .count         (count),
    .empty         (empty)
);

// File: tb/sim_store_backup_queue.sv
module sim_store_backup_queue;
    localparam int DEPTH = 4;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cap_valid, cap_cacheable, inv_valid, discard, mem_wr_ready;
    logic [31:0]   cap_addr, cap_data, inv_addr;
    logic          mem_wr_valid, busy, overflow, empty;
    logic [31:0]   mem_wr_addr, mem_wr_data;
    logic [CW-1:0] count;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    store_backup_queue #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cap_valid(cap_valid), .cap_addr(cap_addr), .cap_data(cap_data),
        .cap_cacheable(cap_cacheable),
        .inv_valid(inv_valid), .inv_addr(inv_addr), .discard(discard),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_ready(mem_wr_ready),
        .busy(busy), .overflow(overflow), .count(count), .empty(empty)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic idle();
        cap_valid = 0; cap_cacheable = 0; inv_valid = 0; discard = 0;
    endtask

    // One request cycle; sampling is 1 ns after the edge that takes it.
    task automatic cap(input logic [31:0] a, input logic [31:0] d, input bit c);
        cap_valid = 1; cap_addr = a; cap_data = d; cap_cacheable = c;
        @(posedge clk); #1; idle();
    endtask

    // Invalidate; checks the write that appears right after the edge, then
    // lets it retire (ready is high).
    task automatic inv_expect(input logic [31:0] a, input bit exp_hit,
                              input logic [31:0] ea, input logic [31:0] ed,
                              input string req);
        inv_valid = 1; inv_addr = a;
        @(posedge clk); #1; idle();
        chk(mem_wr_valid == exp_hit, req, 32'(mem_wr_valid), 32'(exp_hit));
        if (exp_hit) begin
            chk(mem_wr_addr == ea, req, mem_wr_addr, ea);
            chk(mem_wr_data == ed, req, mem_wr_data, ed);
            @(posedge clk); #1;
        end else begin
            chk(busy == 1'b0, req, 32'(busy), 32'd0);
        end
    endtask

    task automatic t_reset();
        chk(count == 0, "R1", 32'(count), 0);
        chk(empty == 1, "R1", 32'(empty), 1);
        chk(mem_wr_valid == 0 && busy == 0, "R1", 32'(mem_wr_valid), 0);
        chk(overflow == 0, "R1", 32'(overflow), 0);
    endtask

    task automatic t_uncached();
        cap(32'h0000_1000, 32'hDEAD_0001, 0);
        chk(count == 0, "R2", 32'(count), 0);
        inv_expect(32'h0000_1000, 0, 0, 0, "R2");
    endtask

    task automatic t_order_and_match();
        cap(32'h0000_0100, 32'hA, 1);
        chk(count == 1, "R3", 32'(count), 1);
        cap(32'h0000_0204, 32'hB, 1);
        cap(32'h0000_011C, 32'hC, 1);
        cap(32'h0000_0300, 32'hD, 1);
        chk(count == 4, "R3", 32'(count), 4);
        // Offset bits differ: still a line match, oldest (head) first.
        inv_expect(32'h0000_011F, 1, 32'h0000_0100, 32'hA, "R4");
        chk(count == 3, "R5", 32'(count), 3);
        // Second match in the same line comes from the middle, full address kept.
        inv_expect(32'h0000_0100, 1, 32'h0000_011C, 32'hC, "R5");
        // Tail entry removed.
        inv_expect(32'h0000_031F, 1, 32'h0000_0300, 32'hD, "R6");
        chk(count == 1, "R6", 32'(count), 1);
        cap(32'h0000_0300, 32'hE, 1);
        // Bit 5 differs: no match.
        inv_expect(32'h0000_0320, 0, 0, 0, "R7");
        inv_expect(32'h0000_02E0, 0, 0, 0, "R7");
        chk(count == 2, "R7", 32'(count), 2);
        inv_expect(32'h0000_0210, 1, 32'h0000_0204, 32'hB, "R6");
        inv_expect(32'h0000_0300, 1, 32'h0000_0300, 32'hE, "R6");
        chk(empty == 1, "R6", 32'(empty), 1);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < DEPTH; i++) cap(32'h1000 + 32'(i) * 32'h40, 32'(i), 1);
        chk(count == DEPTH, "R10", 32'(count), DEPTH);
        cap(32'h0000_2000, 32'h55, 0);
        chk(overflow == 0, "R10", 32'(overflow), 0);
        cap(32'h0000_2000, 32'h55, 1);
        chk(overflow == 1, "R10", 32'(overflow), 1);
        chk(count == DEPTH, "R10", 32'(count), DEPTH);
        @(posedge clk); #1;
        chk(overflow == 0, "R10", 32'(overflow), 0);
        // Dropped entry was never stored.
        inv_expect(32'h0000_2000, 0, 0, 0, "R10");
        discard = 1;
        @(posedge clk); #1; idle();
        chk(count == 0 && empty == 1, "R9", 32'(count), 0);
        chk(mem_wr_valid == 0, "R9", 32'(mem_wr_valid), 0);
    endtask

    task automatic t_busy();
        cap(32'h0000_4000, 32'h11, 1);
        cap(32'h0000_5000, 32'h22, 1);
        mem_wr_ready = 0;
        inv_valid = 1; inv_addr = 32'h0000_4000;
        @(posedge clk); #1; idle();
        chk(busy == 1 && mem_wr_valid == 1, "R8", 32'(busy), 1);
        cap(32'h0000_6000, 32'h33, 1);
        chk(count == 1, "R8", 32'(count), 1);
        inv_valid = 1; inv_addr = 32'h0000_5000;
        @(posedge clk); #1; idle();
        chk(count == 1, "R8", 32'(count), 1);
        chk(mem_wr_addr == 32'h4000 && mem_wr_data == 32'h11, "R8", mem_wr_addr, 32'h4000);
        mem_wr_ready = 1;
        @(posedge clk); #1;
        chk(mem_wr_valid == 0 && busy == 0, "R8", 32'(mem_wr_valid), 0);
        inv_expect(32'h0000_5000, 1, 32'h0000_5000, 32'h22, "R8");
        chk(empty == 1, "R8", 32'(empty), 1);
    endtask

    task automatic t_same_cycle();
        cap(32'h0000_7000, 32'h71, 1);
        cap(32'h0000_8000, 32'h81, 1);
        cap_valid = 1; cap_addr = 32'h0000_9000; cap_data = 32'h91; cap_cacheable = 1;
        inv_valid = 1; inv_addr = 32'h0000_8000;
        @(posedge clk); #1; idle();
        chk(mem_wr_valid && mem_wr_data == 32'h81, "R11", mem_wr_data, 32'h81);
        chk(count == 2, "R11", 32'(count), 2);
        @(posedge clk); #1;
        inv_expect(32'h0000_9000, 1, 32'h0000_9000, 32'h91, "R11");
        inv_expect(32'h0000_7000, 1, 32'h0000_7000, 32'h71, "R11");
    endtask

    task automatic t_discard_priority();
        cap(32'h0000_A000, 32'hA1, 1);
        cap_valid = 1; cap_addr = 32'h0000_B000; cap_data = 32'hB1; cap_cacheable = 1;
        inv_valid = 1; inv_addr = 32'h0000_A000; discard = 1;
        @(posedge clk); #1; idle();
        chk(count == 0, "R9", 32'(count), 0);
        chk(mem_wr_valid == 0, "R9", 32'(mem_wr_valid), 0);
        inv_expect(32'h0000_B000, 0, 0, 0, "R9");
    endtask

    initial begin
        idle();
        cap_addr = 0; cap_data = 0; inv_addr = 0; mem_wr_ready = 1;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_uncached();
        t_order_and_match();
        t_overflow();
        t_busy();
        t_same_cycle();
        t_discard_priority();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule